// File: doc/BRIEF.md
# Chip-Enable Address Decoder

This block turns a 24-bit CPU address into three active-low chip-enable pins for external memory. It is used next to the CPU bus logic. An enable asserts only for an external bus access. It stays inactive for internal accesses, when the bus is idle, and while the CPU is in a standby state.

Which address window drives each enable depends on three settings: the bus mode (64K expanded or 4M expanded), the chip mode (MCU or MPU), and a two-bit chip-size code. Each of the three pins can also be handed back to a general-purpose output bit through a per-pin enable. In that case the pin copies the port data bit. All pins are registered, so they change only on a rising clock edge.

Top module: `ce_addr_decoder`

## Requirements
- R1: While reset is asserted, and until the first edge after the synchronised release, all three pins read 1.
- R2: When a pin's CE-enable bit is 0, the pin drives that pin's port data bit one clock later. This holds whatever the address, the access flags or the standby state are.
- R3: An access flagged as internal (`int_acc`=1) leaves every CE-mode pin at 1.
- R4: With `standby`=1, every CE-mode pin reads 1.
- R5: With `bus_act`=0, every CE-mode pin reads 1.
- R6: At most one chip-enable is selected for any address and mode.
- R7: In 4M mode (`mode_4m`=1), pin 1 goes low for 400000h–7FFFFFh and pin 2 goes low for 800000h–BFFFFFh. Pin 0 goes low for C00000h–FFFFFFh in MCU mode (`mode_mpu`=0). In MPU mode, pin 0 goes low for 000000h–00EFFFh and for 010000h–3FFFFFh.
- R8: In 64K MPU mode, the windows for `size_sel` are:
  - 3: pin 0 at 0000–EFFF.
  - 2: pin 0 at 0000–7FFF and pin 1 at 8000–EFFF.
  - 1: pin 0 at 0000–3FFF, pin 1 at 4000–7FFF and pin 2 at 8000–BFFF.
  - 0: pin 0 at 0000–1FFF, pin 1 at 2000–3FFF and pin 2 at 4000–5FFF.
- R9: In 64K MCU mode, the windows for `size_sel` are:
  - 3: no pin.
  - 2: pin 0 at 8000–EFFF.
  - 1: pin 0 at 8000–AFFF and pin 1 at B000–EFFF.
  - 0: pin 0 at 8000–9FFF, pin 1 at A000–BFFF and pin 2 at C000–DFFF.
- R10: An address outside every window leaves all CE-mode pins at 1. In 64K mode this includes any address whose bits 23..16 are not zero.
- R11: A pin reflects the inputs sampled at a rising edge. It does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | CPU address |
| bus_act | input | 1 | A bus access is in progress |
| int_acc | input | 1 | The access targets internal memory or registers |
| standby | input | 1 | CPU is in a standby state |
| mode_4m | input | 1 | 1: 4M expanded bus, 0: 64K expanded bus |
| mode_mpu | input | 1 | 1: MPU mode, 0: MCU mode |
| size_sel | input | 2 | Chip-size code for the 64K mode |
| ce_en | input | 3 | Per-pin select: 1 chip-enable, 0 port bit |
| port_dat | input | 3 | Port data bits for pins in port mode |
| pin_o | output | 3 | Shared pins (active-low enables or port data) |

## Verification
The hardest cases to reach are the window edges that depend on all three mode inputs together. Examples are the 00F000h hole in 4M MPU mode and the B000h split that exists only in 64K MCU mode with size code 1. The stimulus sets each mode combination in turn and probes the first and last address of every window, plus the address just past it. Mixed pin configurations are the other difficult case: some pins are in port mode while their neighbours are enabled. The bench drives one such configuration under an address that hits the disabled pin, and checks that the port bit wins.

// File: rtl/ced_pkg.sv
package ced_pkg;

  localparam int CED_ADDR_W = 24;
  localparam int CED_NUM_CE = 3;

  typedef struct packed {
    logic        used;
    logic [15:0] lo;
    logic [15:0] hi;
  } win_t;

  // Window of enable idx inside the 64K space.
  function automatic win_t win64(input logic mpu, input logic [1:0] size, input int idx);
    win_t        w;
    logic [15:0] span;
    logic [15:0] base;
    w    = '0;
    span = 16'h0000;
    base = 16'h0000;
    if (mpu) begin
      case (size)
        2'b11: if (idx == 0) w = '{1'b1, 16'h0000, 16'hEFFF};
        2'b10: begin
          if (idx == 0) w = '{1'b1, 16'h0000, 16'h7FFF};
          if (idx == 1) w = '{1'b1, 16'h8000, 16'hEFFF};
        end
        default: begin
          span = (size == 2'b01) ? 16'h4000 : 16'h2000;
          if (idx < 3) begin
            base = 16'(idx) * span;
            w    = '{1'b1, base, base + span - 16'h0001};
          end
        end
      endcase
    end else begin
      case (size)
        2'b11: w = '0;
        2'b10: if (idx == 0) w = '{1'b1, 16'h8000, 16'hEFFF};
        2'b01: begin
          if (idx == 0) w = '{1'b1, 16'h8000, 16'hAFFF};
          if (idx == 1) w = '{1'b1, 16'hB000, 16'hEFFF};
        end
        default: begin
          if (idx < 3) begin
            base = 16'h8000 + 16'(idx) * 16'h2000;
            w    = '{1'b1, base, base + 16'h1FFF};
          end
        end
      endcase
    end
    return w;
  endfunction

  // Quadrant decode in the 4M space; hole = top nibble F of page 0.
  function automatic logic hit4m(input logic mpu, input int idx,
                                 input logic [1:0] quad, input logic page0_hole);
    logic h;
    h = 1'b0;
    case (idx)
      0:       h = mpu ? (quad == 2'b00) && !page0_hole : (quad == 2'b11);
      1:       h = (quad == 2'b01);
      2:       h = (quad == 2'b10);
      default: h = 1'b0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/ced_rst_sync.sv
module ced_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/ced_range_map.sv
module ced_range_map
  import ced_pkg::*;
#(
  parameter int ADDR_W = CED_ADDR_W,
  parameter int NUM_CE = CED_NUM_CE
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode_4m,
  input  logic              mode_mpu,
  input  logic [1:0]        size_sel,
  output logic [NUM_CE-1:0] hit
);
  localparam int PAGE_W = ADDR_W - 16;

  logic             page0;
  logic             hole;
  logic [1:0]       quad;
  logic [15:0]      off;

  assign off   = addr[15:0];
  assign quad  = addr[ADDR_W-1 -: 2];
  assign page0 = (addr[ADDR_W-1 -: PAGE_W] == '0);
  assign hole  = (addr[ADDR_W-3:16] == '0) && (addr[15:12] == 4'hF);

  for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
    win_t w;
    logic in64;
    logic in4m;
    assign w    = win64(mode_mpu, size_sel, i);
    assign in64 = page0 && w.used && (off >= w.lo) && (off <= w.hi);
    assign in4m = hit4m(mode_mpu, i, quad, hole);
    assign hit[i] = mode_4m ? in4m : in64;
  end
endmodule

// File: rtl/ced_pin_stage.sv
module ced_pin_stage #(
  parameter int NUM_CE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CE-1:0] hit,
  input  logic              bus_act,
  input  logic              int_acc,
  input  logic              standby,
  input  logic [NUM_CE-1:0] ce_en,
  input  logic [NUM_CE-1:0] port_dat,
  output logic [NUM_CE-1:0] pin_o
);
  logic              acc_ok;
  logic [NUM_CE-1:0] pin_d;
  logic [NUM_CE-1:0] pin_q;

  assign acc_ok = bus_act && !int_acc && !standby;

  always_comb begin
    for (int i = 0; i < NUM_CE; i++) begin
      pin_d[i] = ce_en[i] ? !(hit[i] && acc_ok) : port_dat[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '1;
    else        pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  for (genvar i = 0; i < NUM_CE; i++) begin : g_chk
    a_r2_port_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ce_en[i]) |-> (pin_o[i] == $past(port_dat[i])));
    a_r3_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ce_en[i]) && $past(int_acc)) |-> pin_o[i]);
    a_r4_standby_high: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ce_en[i]) && $past(standby)) |-> pin_o[i]);
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ce_en[i]) && !$past(bus_act)) |-> pin_o[i]);
  end
endmodule

// File: rtl/ce_addr_decoder.sv
module ce_addr_decoder
  import ced_pkg::*;
#(
  parameter int ADDR_W      = CED_ADDR_W,
  parameter int NUM_CE      = CED_NUM_CE,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bus_act,
  input  logic              int_acc,
  input  logic              standby,
  input  logic              mode_4m,
  input  logic              mode_mpu,
  input  logic [1:0]        size_sel,
  input  logic [NUM_CE-1:0] ce_en,
  input  logic [NUM_CE-1:0] port_dat,
  output logic [NUM_CE-1:0] pin_o
);
  logic              rst_n_s;
  logic [NUM_CE-1:0] hit;

  ced_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  ced_range_map #(.ADDR_W(ADDR_W), .NUM_CE(NUM_CE)) u_map (
    .addr(addr), .mode_4m(mode_4m), .mode_mpu(mode_mpu),
    .size_sel(size_sel), .hit(hit)
  );

  ced_pin_stage #(.NUM_CE(NUM_CE)) u_pins (
    .clk(clk), .rst_n(rst_n_s), .hit(hit), .bus_act(bus_act),
    .int_acc(int_acc), .standby(standby), .ce_en(ce_en),
    .port_dat(port_dat), .pin_o(pin_o)
  );

  a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(hit));
  a_r10_upper_page: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!mode_4m && (addr[ADDR_W-1:16] != '0)) |-> (hit == '0));
  a_r7_quadrant_unique: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_4m && (addr[ADDR_W-1 -: 2] == 2'b01)) |-> (hit == 3'b010));
endmodule

// File: tb/ce_addr_decoder_bench.sv
module ce_addr_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        bus_act = 1'b1, int_acc = 1'b0, standby = 1'b0;
  logic        mode_4m = 1'b0, mode_mpu = 1'b1;
  logic [1:0]  size_sel = 2'b11;
  logic [2:0]  ce_en = 3'b111, port_dat = 3'b000;
  logic [2:0]  pin_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  ce_addr_decoder u_ce_addr_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .bus_act(bus_act),
    .int_acc(int_acc), .standby(standby), .mode_4m(mode_4m),
    .mode_mpu(mode_mpu), .size_sel(size_sel), .ce_en(ce_en),
    .port_dat(port_dat), .pin_o(pin_o)
  );

  task automatic check(input string req, input logic [2:0] exp);
    n_chk++;
    if (pin_o !== exp) begin
      n_err++;
      $display("FAIL %s addr=%h: pins=%b expected=%b", req, addr, pin_o, exp);
    end
  endtask

  task automatic probe(input string req, input logic [23:0] a, input logic [2:0] exp);
    addr = a;
    @(posedge clk); #1;
    check(req, exp);
  endtask

  task automatic set_mode(input logic m4, input logic mpu, input logic [1:0] sz);
    mode_4m = m4; mode_mpu = mpu; size_sel = sz;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", 3'b111);
    rst_n = 1'b1;
    @(posedge clk); #1 check("R1 sync release", 3'b111);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_4m;
    set_mode(1, 0, 2'b00);
    probe("R7 mcu ce0", 24'hC00000, 3'b110);
    probe("R7 mcu ce1", 24'h7FFFFF, 3'b101);
    probe("R7 mcu ce2", 24'h800000, 3'b011);
    probe("R7 mcu low", 24'h3FFFFF, 3'b111);
    set_mode(1, 1, 2'b00);
    probe("R7 mpu ce0 base", 24'h000000, 3'b110);
    probe("R7 mpu ce0 top", 24'h00EFFF, 3'b110);
    probe("R7 mpu hole", 24'h00F000, 3'b111);
    probe("R7 mpu ce0 upper", 24'h010000, 3'b110);
    probe("R7 mpu ce0 end", 24'h3FFFFF, 3'b110);
    probe("R7 mpu top quad", 24'hC00000, 3'b111);
  endtask

  task automatic t_64_mpu;
    set_mode(0, 1, 2'b11);
    probe("R8 s3 base", 24'h000000, 3'b110);
    probe("R8 s3 top", 24'h00EFFF, 3'b110);
    probe("R8 s3 past", 24'h00F000, 3'b111);
    set_mode(0, 1, 2'b10);
    probe("R8 s2 ce0", 24'h007FFF, 3'b110);
    probe("R8 s2 ce1", 24'h008000, 3'b101);
    probe("R8 s2 ce1 top", 24'h00EFFF, 3'b101);
    probe("R8 s2 past", 24'h00F000, 3'b111);
    set_mode(0, 1, 2'b01);
    probe("R8 s1 ce0", 24'h003FFF, 3'b110);
    probe("R8 s1 ce1", 24'h004000, 3'b101);
    probe("R8 s1 ce2", 24'h00BFFF, 3'b011);
    probe("R8 s1 past", 24'h00C000, 3'b111);
    set_mode(0, 1, 2'b00);
    probe("R8 s0 ce0", 24'h001FFF, 3'b110);
    probe("R8 s0 ce1", 24'h002000, 3'b101);
    probe("R8 s0 ce2", 24'h005FFF, 3'b011);
    probe("R8 s0 past", 24'h006000, 3'b111);
  endtask

  task automatic t_64_mcu;
    set_mode(0, 0, 2'b11);
    probe("R9 s3 none", 24'h008000, 3'b111);
    set_mode(0, 0, 2'b10);
    probe("R9 s2 below", 24'h007FFF, 3'b111);
    probe("R9 s2 ce0", 24'h008000, 3'b110);
    probe("R9 s2 ce0 top", 24'h00EFFF, 3'b110);
    probe("R9 s2 past", 24'h00F000, 3'b111);
    set_mode(0, 0, 2'b01);
    probe("R9 s1 ce0", 24'h00AFFF, 3'b110);
    probe("R9 s1 ce1", 24'h00B000, 3'b101);
    probe("R9 s1 ce1 top", 24'h00EFFF, 3'b101);
    set_mode(0, 0, 2'b00);
    probe("R9 s0 ce0", 24'h009FFF, 3'b110);
    probe("R9 s0 ce1", 24'h00A000, 3'b101);
    probe("R9 s0 ce2", 24'h00C000, 3'b011);
    probe("R9 s0 ce2 top", 24'h00DFFF, 3'b011);
    probe("R9 s0 past", 24'h00E000, 3'b111);
  endtask

  task automatic t_outside;
    set_mode(0, 1, 2'b11);
    probe("R10 upper page", 24'h010000, 3'b111);
    probe("R10 far page", 24'hFF0000, 3'b111);
    probe("R6 single enable", 24'h000100, 3'b110);
  endtask

  task automatic t_qualifiers;
    set_mode(0, 1, 2'b11);
    int_acc = 1'b1;
    probe("R3 internal", 24'h000000, 3'b111);
    int_acc = 1'b0; bus_act = 1'b0;
    probe("R5 bus idle", 24'h000000, 3'b111);
    bus_act = 1'b1; standby = 1'b1;
    probe("R4 standby", 24'h000000, 3'b111);
    ce_en = 3'b000; port_dat = 3'b101;
    probe("R2 port in standby", 24'h000000, 3'b101);
    standby = 1'b0; ce_en = 3'b111; port_dat = 3'b000;
  endtask

  task automatic t_port;
    set_mode(0, 1, 2'b10);
    ce_en = 3'b010; port_dat = 3'b000;
    probe("R2 mix ce1 hit", 24'h008000, 3'b000);
    probe("R2 ce0 disabled", 24'h000000, 3'b010);
    port_dat = 3'b101;
    probe("R2 port data", 24'h000000, 3'b111);
    ce_en = 3'b111; port_dat = 3'b000;
  endtask

  task automatic t_latency;
    set_mode(0, 1, 2'b11);
    probe("R11 settle", 24'h00F000, 3'b111);
    addr = 24'h000000;
    #1 check("R11 before edge", 3'b111);
    @(posedge clk); #1 check("R11 after edge", 3'b110);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog: pins=%b expected=completion", pin_o);
    finish_run();
  end

  initial begin
    #1;
    t_reset();
    t_4m();
    t_64_mpu();
    t_64_mcu();
    t_outside();
    t_qualifiers();
    t_port();
    t_latency();
    finish_run();
  end
endmodule